// File: doc/BRIEF.md
# Multi-Master I2C Master Engine with Arbitration Recovery

This block is the master side of an I2C port on a bus that other masters may share. Software-style command pulses ask it to generate a START, a repeated START, a STOP or a master acknowledge bit. A byte written into its transmit buffer is sent most significant bit first whenever the engine holds the bus. The engine drives both open-drain lines as pull-low enables and reads back the real wired-AND levels through a two-flop synchronizer. A free-running line monitor watches those synchronized levels for START and STOP from any master, so the engine always knows whether the bus is free.

Whenever the engine releases SDA to send a one, it samples the line in the middle of the SCL high phase. If the line reads low, another master has won arbitration. This check runs in every phase: START, repeated START, address or data bits, master acknowledge and STOP. On a loss the engine sets a sticky collision flag, releases both lines, returns to idle, drops every pending command and empties the transmit buffer. The next buffer write is then sent from its first bit. The monitor keeps running afterwards and raises the stop interrupt when the winning master ends its transfer.

Each SCL period is four quarters of `QTR` clocks. SDA changes only in the SCL-low quarters, and the arbitration sample is taken at the end of the first SCL-high quarter. The FSM states are `ST_IDLE`, `ST_START`, `ST_RSTART`, `ST_HOLD` (bus owned, SCL held low), `ST_DATA` (eight data bits and a released acknowledge slot), `ST_ACK` and `ST_STOP`. The transitions are:
- IDLE to START when a START is pending and the bus is free.
- HOLD to DATA, RSTART, STOP or ACK, taken in that priority order.
- START, RSTART, DATA (after the acknowledge slot) and ACK return to HOLD.
- STOP returns to IDLE.
- Any state goes to IDLE on a collision or when `enable` is low.

Top module: `i2c_arb_master`

## Requirements
- R1: A START is detected when synchronized SDA falls while synchronized SCL has been high for two samples. A STOP is detected when SDA rises under the same SCL condition. A START sets `start_seen` and clears `stop_seen`, and a STOP does the reverse. `bus_free` is 1 when `stop_seen` is set or when both bits are clear.
- R2: A START command given while the bus is not free is dropped, and `cmd_reject` is set with no line activity. A `tx_write` while `buf_full` is 1 is ignored, and it also sets `cmd_reject`.
- R3: A buffered byte is sent MSB first, once the bus is held, in the SCL-low quarters. A ninth clock follows with SDA released, and its sampled level lands in `ack_rcvd`. `buf_full` clears when the byte ends.
- R4: A collision occurs when SDA reads low at the arbitration sample point while the engine is releasing it and SCL is high. This is checked during START, repeated START, data bits, master acknowledge with `ack_value`=1, and STOP. A collision sets `coll_flag`, releases `scl_oe` and `sda_oe`, and returns the engine to idle.
- R5: A collision clears `buf_full` and every pending bit. The bits of `pend` are: bit0 START, bit1 repeated START, bit2 STOP, bit3 acknowledge.
- R6: `stop_irq` is set by every detected STOP from any master, including after a collision. `flag_clr` clears `stop_irq`, `coll_flag` and `cmd_reject`.
- R7: The first buffer write after a collision is transmitted from its MSB.
- R8: `enable` low (and reset) releases both lines and clears `start_seen`, `stop_seen`, `buf_full` and `pend`.
- R9: A pending command bit clears when its command completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Engine and monitor enable |
| cmd_start | input | 1 | Pulse: request START |
| cmd_rstart | input | 1 | Pulse: request repeated START |
| cmd_stop | input | 1 | Pulse: request STOP |
| cmd_ack | input | 1 | Pulse: request master acknowledge bit |
| ack_value | input | 1 | Level for acknowledge bit (0 = ACK, 1 = NACK), latched on `cmd_ack` |
| tx_write | input | 1 | Pulse: write `tx_data` into transmit buffer |
| tx_data | input | 8 | Transmit byte |
| flag_clr | input | 1 | Clears sticky flags |
| scl_in | input | 1 | Actual SCL line level |
| sda_in | input | 1 | Actual SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| pend | output | 4 | Pending command bits |
| buf_full | output | 1 | Transmit buffer holds an unsent byte |
| ack_rcvd | output | 1 | SDA level sampled in the last acknowledge slot |
| coll_flag | output | 1 | Sticky bus-collision flag |
| cmd_reject | output | 1 | Sticky rejected-command flag |
| stop_irq | output | 1 | Sticky STOP-detected interrupt |
| start_seen | output | 1 | Last bus event was a START |
| stop_seen | output | 1 | Last bus event was a STOP |
| bus_free | output | 1 | Bus may be claimed |

## Verification
A state register that fails to leave a transfer state after a collision shows within one clock as a pull-low enable still asserted next to a freshly set `coll_flag`. A pending bit or buffer flag that survives an abort shows at `pend` or `buf_full` in that same cycle. A broken shift register or bit counter shows at the end of the next byte, as a wrong value in the nine bits the bench captures on SCL rising edges. A monitor fault shows a few clocks after a line edge as wrong `start_seen`, `stop_seen` or `bus_free` values.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_RSTART,
        ST_HOLD,
        ST_DATA,
        ST_ACK,
        ST_STOP
    } eng_state_t;

    localparam int unsigned PEND_START  = 0;
    localparam int unsigned PEND_RSTART = 1;
    localparam int unsigned PEND_STOP   = 2;
    localparam int unsigned PEND_ACK    = 3;
    localparam int unsigned PEND_W      = 4;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= '1;
        else        stg_q[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[i] <= '1;
            else        stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_s,
    input  logic sda_s,
    input  logic flag_clr,
    output logic start_seen,
    output logic stop_seen,
    output logic bus_free,
    output logic stop_irq
);
    logic scl_prev_q, sda_prev_q;
    logic start_det, stop_det;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_s;
            sda_prev_q <= sda_s;
        end
    end

    assign start_det = scl_s && scl_prev_q && sda_prev_q && !sda_s;
    assign stop_det  = scl_s && scl_prev_q && !sda_prev_q && sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_seen <= 1'b0;
            stop_seen  <= 1'b0;
            stop_irq   <= 1'b0;
        end else if (!enable) begin
            start_seen <= 1'b0;
            stop_seen  <= 1'b0;
            stop_irq   <= 1'b0;
        end else begin
            if (start_det) begin
                start_seen <= 1'b1;
                stop_seen  <= 1'b0;
            end else if (stop_det) begin
                start_seen <= 1'b0;
                stop_seen  <= 1'b1;
            end
            if (stop_det)      stop_irq <= 1'b1;
            else if (flag_clr) stop_irq <= 1'b0;
        end
    end

    assign bus_free = stop_seen || !start_seen;
endmodule

// File: rtl/i2c_qtr_timer.sv
module i2c_qtr_timer #(
    parameter int unsigned QTR = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (QTR > 1) ? $clog2(QTR) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (!run)          cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/i2c_arb_master.sv
module i2c_arb_master
    import i2c_arb_pkg::*;
#(
    parameter int unsigned QTR         = 5,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              cmd_start,
    input  logic              cmd_rstart,
    input  logic              cmd_stop,
    input  logic              cmd_ack,
    input  logic              ack_value,
    input  logic              tx_write,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              flag_clr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [PEND_W-1:0] pend,
    output logic              buf_full,
    output logic              ack_rcvd,
    output logic              coll_flag,
    output logic              cmd_reject,
    output logic              stop_irq,
    output logic              start_seen,
    output logic              stop_seen,
    output logic              bus_free
);
    localparam int unsigned BCW = $clog2(DATA_W + 1);
    localparam logic [BCW-1:0] ACK_SLOT = BCW'(DATA_W);

    // synchronized line levels
    logic [1:0] ln_raw, ln_s;
    logic       scl_s, sda_s;
    assign ln_raw = {scl_in, sda_in};

    i2c_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst_n (rst_n), .d (ln_raw), .q (ln_s)
    );
    assign scl_s = ln_s[1];
    assign sda_s = ln_s[0];

    i2c_bus_monitor u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .flag_clr   (flag_clr),
        .start_seen (start_seen),
        .stop_seen  (stop_seen),
        .bus_free   (bus_free),
        .stop_irq   (stop_irq)
    );

    eng_state_t        state_q, state_d;
    logic [1:0]        qtr_q;
    logic [BCW-1:0]    bit_q;
    logic [DATA_W-1:0] txbuf_q, shreg_q;
    logic [PEND_W-1:0] pend_q, pend_d;
    logic buf_full_q, ack_bit_q, sda_hold_q, coll_q, rej_q, ack_rcvd_q;
    logic waiting, tick, qtr_last, ack_slot, chk_en, coll_evt, rej_set;
    logic start_done, rstart_done, stop_done, ack_done, byte_done;
    logic scl_oe_c, sda_oe_c;

    assign waiting  = (state_q == ST_IDLE) || (state_q == ST_HOLD);
    assign qtr_last = tick && (qtr_q == 2'd3);
    assign ack_slot = (bit_q == ACK_SLOT);

    i2c_qtr_timer #(.QTR(QTR)) u_tmr (
        .clk (clk), .rst_n (rst_n), .run (!waiting), .tick (tick)
    );

    // next-state logic and arbitration sample points
    always_comb begin
        state_d = state_q;
        chk_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pend_q[PEND_START] && bus_free) state_d = ST_START;
            end
            ST_HOLD: begin
                if (buf_full_q)                state_d = ST_DATA;
                else if (pend_q[PEND_RSTART])  state_d = ST_RSTART;
                else if (pend_q[PEND_STOP])    state_d = ST_STOP;
                else if (pend_q[PEND_ACK])     state_d = ST_ACK;
            end
            ST_START: begin
                chk_en = tick && (qtr_q == 2'd1);
                if (qtr_last) state_d = ST_HOLD;
            end
            ST_RSTART: begin
                chk_en = tick && (qtr_q == 2'd2);
                if (qtr_last) state_d = ST_HOLD;
            end
            ST_DATA: begin
                chk_en = tick && (qtr_q == 2'd2) && !ack_slot && shreg_q[DATA_W-1];
                if (qtr_last && ack_slot) state_d = ST_HOLD;
            end
            ST_ACK: begin
                chk_en = tick && (qtr_q == 2'd2) && ack_bit_q;
                if (qtr_last) state_d = ST_HOLD;
            end
            ST_STOP: begin
                chk_en = tick && (qtr_q == 2'd3);
                if (qtr_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        coll_evt = chk_en && scl_s && !sda_s;
        if (coll_evt || !enable) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign start_done  = (state_q == ST_START)  && qtr_last && !coll_evt;
    assign rstart_done = (state_q == ST_RSTART) && qtr_last && !coll_evt;
    assign stop_done   = (state_q == ST_STOP)   && qtr_last && !coll_evt;
    assign ack_done    = (state_q == ST_ACK)    && qtr_last && !coll_evt;
    assign byte_done   = (state_q == ST_DATA)   && qtr_last && ack_slot;

    // pending command bits
    always_comb begin
        pend_d  = pend_q;
        rej_set = 1'b0;
        if (start_done)  pend_d[PEND_START]  = 1'b0;
        if (rstart_done) pend_d[PEND_RSTART] = 1'b0;
        if (stop_done)   pend_d[PEND_STOP]   = 1'b0;
        if (ack_done)    pend_d[PEND_ACK]    = 1'b0;
        if (state_q == ST_IDLE) begin
            pend_d[PEND_RSTART] = 1'b0;
            pend_d[PEND_STOP]   = 1'b0;
            pend_d[PEND_ACK]    = 1'b0;
            if (pend_q[PEND_START] && !bus_free) begin
                pend_d[PEND_START] = 1'b0;
                rej_set            = 1'b1;
            end
        end
        if ((state_q == ST_HOLD) && pend_q[PEND_START]) begin
            pend_d[PEND_START] = 1'b0;
            rej_set            = 1'b1;
        end
        pend_d = pend_d | {cmd_ack, cmd_stop, cmd_rstart, cmd_start};
        if (tx_write && buf_full_q) rej_set = 1'b1;
        if (coll_evt || !enable) pend_d = '0;
    end

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qtr_q      <= '0;
            bit_q      <= '0;
            txbuf_q    <= '0;
            shreg_q    <= '0;
            pend_q     <= '0;
            buf_full_q <= 1'b0;
            ack_bit_q  <= 1'b0;
            sda_hold_q <= 1'b0;
            coll_q     <= 1'b0;
            rej_q      <= 1'b0;
            ack_rcvd_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
            if (waiting)   qtr_q <= '0;
            else if (tick) qtr_q <= qtr_q + 2'd1;

            if (state_q == ST_HOLD) begin
                bit_q <= '0;
                if (state_d == ST_DATA) shreg_q <= txbuf_q;
            end else if ((state_q == ST_DATA) && qtr_last) begin
                bit_q   <= bit_q + 1'b1;
                shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
            end

            if ((state_q == ST_DATA) && ack_slot && tick && (qtr_q == 2'd2))
                ack_rcvd_q <= sda_s;

            if (state_q != ST_HOLD) sda_hold_q <= sda_oe_c;

            if (cmd_ack) ack_bit_q <= ack_value;

            if (!enable || coll_evt || byte_done) begin
                buf_full_q <= 1'b0;
            end else if (tx_write && !buf_full_q) begin
                buf_full_q <= 1'b1;
                txbuf_q    <= tx_data;
            end

            if (!enable)       coll_q <= 1'b0;
            else if (coll_evt) coll_q <= 1'b1;
            else if (flag_clr) coll_q <= 1'b0;

            if (!enable)       rej_q <= 1'b0;
            else if (rej_set)  rej_q <= 1'b1;
            else if (flag_clr) rej_q <= 1'b0;
        end
    end

    // line drive per state and quarter (1 = pull low)
    always_comb begin
        scl_oe_c = 1'b0;
        sda_oe_c = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                scl_oe_c = 1'b0;
                sda_oe_c = 1'b0;
            end
            ST_HOLD: begin
                scl_oe_c = 1'b1;
                sda_oe_c = sda_hold_q;
            end
            ST_START: begin
                scl_oe_c = 1'b0;
                sda_oe_c = qtr_q[1];
            end
            ST_RSTART: begin
                scl_oe_c = (qtr_q == 2'd0);
                sda_oe_c = (qtr_q == 2'd3);
            end
            ST_DATA: begin
                scl_oe_c = !qtr_q[1];
                sda_oe_c = ack_slot ? 1'b0 : !shreg_q[DATA_W-1];
            end
            ST_ACK: begin
                scl_oe_c = !qtr_q[1];
                sda_oe_c = !ack_bit_q;
            end
            ST_STOP: begin
                scl_oe_c = (qtr_q == 2'd0);
                sda_oe_c = (qtr_q != 2'd3);
            end
            default: begin
                scl_oe_c = 1'b0;
                sda_oe_c = 1'b0;
            end
        endcase
    end

    assign scl_oe     = scl_oe_c;
    assign sda_oe     = sda_oe_c;
    assign pend       = pend_q;
    assign buf_full   = buf_full_q;
    assign ack_rcvd   = ack_rcvd_q;
    assign coll_flag  = coll_q;
    assign cmd_reject = rej_q;
endmodule

// File: rtl/i2c_arb_master_chk.sv
module i2c_arb_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic [3:0] pend,
    input logic       buf_full,
    input logic       coll_flag,
    input logic       stop_irq,
    input logic       start_seen,
    input logic       stop_seen
);
    AST_COLL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coll_flag) |-> (!scl_oe && !sda_oe)); // R4

    AST_COLL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coll_flag) |-> (pend == 4'd0 && !buf_full)); // R5

    AST_STOP_IRQ_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_irq) |-> (stop_seen && !start_seen)); // R6

    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_oe && !sda_oe && !start_seen && !stop_seen
                     && !buf_full && pend == 4'd0)); // R8
endmodule

bind i2c_arb_master i2c_arb_master_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .pend       (pend),
    .buf_full   (buf_full),
    .coll_flag  (coll_flag),
    .stop_irq   (stop_irq),
    .start_seen (start_seen),
    .stop_seen  (stop_seen)
);

// File: tb/test_i2c_arb_master.sv
module test_i2c_arb_master;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1;
    logic cmd_start = 0, cmd_rstart = 0, cmd_stop = 0, cmd_ack = 0, ack_value = 0;
    logic tx_write = 0, flag_clr = 0;
    logic [7:0] tx_data = 8'h00;
    logic oth_sda = 1'b0;
    logic scl_oe, sda_oe, buf_full, ack_rcvd, coll_flag, cmd_reject;
    logic stop_irq, start_seen, stop_seen, bus_free;
    logic [3:0] pend;
    logic scl_bus, sda_bus;
    logic [8:0] cap = 9'h0;
    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    assign scl_bus = ~scl_oe;
    assign sda_bus = ~(sda_oe | oth_sda);

    always @(posedge scl_bus) cap <= {cap[7:0], sda_bus};

    i2c_arb_master i_i2c_arb_master (
        .clk (clk), .rst_n (rst_n), .enable (enable),
        .cmd_start (cmd_start), .cmd_rstart (cmd_rstart), .cmd_stop (cmd_stop),
        .cmd_ack (cmd_ack), .ack_value (ack_value), .tx_write (tx_write),
        .tx_data (tx_data), .flag_clr (flag_clr), .scl_in (scl_bus), .sda_in (sda_bus),
        .scl_oe (scl_oe), .sda_oe (sda_oe), .pend (pend), .buf_full (buf_full),
        .ack_rcvd (ack_rcvd), .coll_flag (coll_flag), .cmd_reject (cmd_reject),
        .stop_irq (stop_irq), .start_seen (start_seen), .stop_seen (stop_seen),
        .bus_free (bus_free)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();  cmd_start = 1;  cyc(1); cmd_start = 0;  endtask
    task automatic pulse_rstart(); cmd_rstart = 1; cyc(1); cmd_rstart = 0; endtask
    task automatic pulse_stop();   cmd_stop = 1;   cyc(1); cmd_stop = 0;   endtask
    task automatic pulse_clr();    flag_clr = 1;   cyc(1); flag_clr = 0;   endtask
    task automatic pulse_ack(input logic v);
        ack_value = v; cmd_ack = 1; cyc(1); cmd_ack = 0;
    endtask
    task automatic write_byte(input logic [7:0] b);
        tx_data = b; tx_write = 1; cyc(1); tx_write = 0;
    endtask

    task automatic wait_pend_zero();
        for (int i = 0; i < 400 && pend != 4'd0; i++) cyc(1);
    endtask
    task automatic wait_buf_empty();
        for (int i = 0; i < 600 && buf_full; i++) cyc(1);
    endtask
    task automatic wait_coll();
        for (int i = 0; i < 600 && !coll_flag; i++) cyc(1);
    endtask

    task automatic claim_bus();
        pulse_start();
        wait_pend_zero();
        cyc(2);
    endtask

    task automatic release_other_and_check(input string tag);
        pulse_clr();
        oth_sda = 1'b0;
        cyc(8);
        chk(stop_irq == 1'b1, tag, stop_irq, 1);
        chk(bus_free == 1'b1, tag, bus_free, 1);
    endtask

    task automatic t_reset();
        cyc(2);
        chk(scl_oe == 0 && sda_oe == 0, "R8 reset lines released", {scl_oe, sda_oe}, 0);
        chk(start_seen == 0 && stop_seen == 0, "R8 reset seen bits", {start_seen, stop_seen}, 0);
        chk(bus_free == 1, "R1 reset bus free", bus_free, 1);
        chk(pend == 0 && buf_full == 0 && coll_flag == 0, "R8 reset flags",
            {pend, buf_full, coll_flag}, 0);
    endtask

    task automatic t_write_stop();
        claim_bus();
        chk(pend == 4'd0, "R9 start pend cleared", pend, 0);
        chk(start_seen == 1 && bus_free == 0, "R1 own START seen", {start_seen, bus_free}, 2);
        chk(scl_oe == 1, "R3 SCL held after START", scl_oe, 1);
        write_byte(8'hA5);
        wait_buf_empty();
        cyc(1);
        chk(cap[8:1] == 8'hA5, "R3 byte on bus", cap[8:1], 8'hA5);
        chk(ack_rcvd == 1, "R3 released ack slot", ack_rcvd, 1);
        pulse_stop();
        wait_pend_zero();
        cyc(6);
        chk(stop_irq == 1 && stop_seen == 1 && bus_free == 1, "R6 own STOP",
            {stop_irq, stop_seen, bus_free}, 7);
        chk(scl_oe == 0 && sda_oe == 0, "R9 idle after STOP", {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_busy_reject();
        pulse_clr();
        oth_sda = 1'b1;
        cyc(6);
        chk(bus_free == 0 && start_seen == 1, "R1 foreign START", {bus_free, start_seen}, 1);
        pulse_start();
        cyc(40);
        chk(cmd_reject == 1, "R2 START rejected", cmd_reject, 1);
        chk(scl_oe == 0 && pend == 0, "R2 no activity", {scl_oe, pend}, 0);
        release_other_and_check("R6 foreign STOP");
    endtask

    task automatic t_data_coll();
        pulse_clr();
        claim_bus();
        oth_sda = 1'b1;
        write_byte(8'hFF);
        wait_coll();
        chk(coll_flag == 1, "R4 data collision", coll_flag, 1);
        chk(buf_full == 0 && pend == 0, "R5 data coll clears", {buf_full, pend}, 0);
        chk(scl_oe == 0 && sda_oe == 0, "R4 lines released", {scl_oe, sda_oe}, 0);
        release_other_and_check("R6 STOP after collision");
        pulse_clr();
        claim_bus();
        write_byte(8'h5A);
        wait_buf_empty();
        cyc(1);
        chk(cap[8:1] == 8'h5A, "R7 restart from MSB", cap[8:1], 8'h5A);
        chk(coll_flag == 0, "R7 no new collision", coll_flag, 0);
        pulse_stop();
        wait_pend_zero();
        cyc(6);
    endtask

    task automatic t_start_coll();
        pulse_clr();
        pulse_start();
        cyc(3);
        oth_sda = 1'b1;
        wait_coll();
        chk(coll_flag == 1, "R4 START collision", coll_flag, 1);
        chk(pend == 0, "R5 START pend cleared", pend, 0);
        release_other_and_check("R6 STOP after START coll");
    endtask

    task automatic t_rstart_coll();
        pulse_clr();
        claim_bus();
        oth_sda = 1'b1;
        pulse_rstart();
        wait_coll();
        chk(coll_flag == 1, "R4 RSTART collision", coll_flag, 1);
        chk(pend == 0, "R5 RSTART pend cleared", pend, 0);
        release_other_and_check("R6 STOP after RSTART coll");
    endtask

    task automatic t_ack_coll();
        pulse_clr();
        claim_bus();
        oth_sda = 1'b1;
        pulse_ack(1'b1);
        wait_coll();
        chk(coll_flag == 1, "R4 ACK collision", coll_flag, 1);
        chk(pend == 0, "R5 ACK pend cleared", pend, 0);
        release_other_and_check("R6 STOP after ACK coll");
    endtask

    task automatic t_stop_coll();
        pulse_clr();
        claim_bus();
        oth_sda = 1'b1;
        pulse_stop();
        wait_coll();
        chk(coll_flag == 1, "R4 STOP collision", coll_flag, 1);
        chk(pend == 0, "R5 STOP pend cleared", pend, 0);
        release_other_and_check("R6 STOP after STOP coll");
    endtask

    task automatic t_write_reject();
        pulse_clr();
        write_byte(8'h3C);
        write_byte(8'h77);
        chk(cmd_reject == 1 && buf_full == 1, "R2 write while full", {cmd_reject, buf_full}, 3);
        claim_bus();
        wait_buf_empty();
        cyc(1);
        chk(cap[8:1] == 8'h3C, "R2 first byte kept", cap[8:1], 8'h3C);
        pulse_stop();
        wait_pend_zero();
        cyc(6);
    endtask

    task automatic t_disable();
        claim_bus();
        write_byte(8'h00);
        cyc(30);
        enable = 1'b0;
        cyc(2);
        chk(scl_oe == 0 && sda_oe == 0, "R8 disable releases", {scl_oe, sda_oe}, 0);
        chk(start_seen == 0 && stop_seen == 0, "R8 disable seen", {start_seen, stop_seen}, 0);
        chk(buf_full == 0 && pend == 0, "R8 disable clears", {buf_full, pend}, 0);
        enable = 1'b1;
        cyc(4);
        chk(bus_free == 1, "R1 free after re-enable", bus_free, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        t_reset();
        t_write_stop();
        t_busy_reject();
        t_data_coll();
        t_start_coll();
        t_rstart_coll();
        t_ack_coll();
        t_stop_coll();
        t_write_reject();
        t_disable();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule